// File: doc/BRIEF.md
# Edge-Counting Down Timer with Dual Interrupt Sources

This block is a 16-bit down-counter that counts transitions of an external count pin instead of ticks of the internal clock. The pin passes through a two-flop synchronizer. It is then compared with its value from the previous cycle, so each qualifying transition produces exactly one count step. A control bit chooses whether rising or falling transitions count. When a count step hits a counter that already holds zero, the counter takes the reload value and a sticky pending flag is raised.

A second external pin does not take part in counting. Every rising transition on it raises its own sticky pending flag. Each flag has its own enable, and the single interrupt output is active while any enabled flag is set. Software reaches the counter, the reload value, the control bits and the flags through a small byte-wide register bus. Reads are combinational, and writes take effect at the next clock edge. No waveform output is driven, because the first pin serves as the count input.

Top module: `evt_counter_timer`

## Requirements
- R1: After reset the counter, the reload value, the control register and both pending flags read as zero, and `irq` is low.
- R2: The counter changes only on a counting step or on a bus write to one of its bytes. Otherwise it holds its value.
- R3: Each qualifying transition of `cntPin` lowers a nonzero counter by exactly one. A transition driven before clock edge k becomes visible in the counter after clock edge k+2.
- R4: Bit 0 of the control register (address 4) selects the counting transition: 0 counts rising transitions only, 1 counts falling transitions only. Changing this bit while the pin is steady produces no count step.
- R5: A counting step while the counter holds zero loads the reload value into the counter and sets pending A (status register at address 5, bit 0).
- R6: Every rising transition of `evtPin` sets pending B (status bit 1). Falling transitions of `evtPin` are ignored, and the pin never changes the counter.
- R7: Pending flags stay set until a write to address 5 with a 1 in the flag's bit. A 0 bit leaves the flag unchanged. When a set event and a clearing write land in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when (pending A and enable A, control bit 1) or (pending B and enable B, control bit 2) holds.
- R9: Addresses 0 and 1 access the counter's low and high bytes, and addresses 2 and 3 access the reload value's low and high bytes. A counter write is visible at the next clock edge. A counting transition that lands in the same cycle as a counter write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntPin | input | 1 | Asynchronous external count pin |
| evtPin | input | 1 | Asynchronous external interrupt pin |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for busAddr |
| irq | output | 1 | Combined interrupt request |

## Verification
A synchronizer or edge detector that holds the wrong state shows up as a missed step or a doubled step in the counter. It is visible on the bus within three clock edges of the pin change, and the bench samples the counter exactly at that boundary. A wrong reload or underflow path shows up at the first step from zero, where the counter reads something other than the reload value and status bit 0 stays low. Flag faults show up on `irq` in the cycle after the flag changes, and an inverted set/clear priority shows up only when a set and a clear collide, so the bench places one collision at a cycle computed from the synchronizer depth.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int LANES   = CNT_W / BYTE_W;
  localparam int ADDR_W  = 3;
  localparam int SYNC_N  = 2;
  localparam int CTRL_ADDR = 2 * LANES;
  localparam int STAT_ADDR = 2 * LANES + 1;

  typedef struct packed {
    logic              dec;
    logic [LANES-1:0]  cntLd;
    logic [LANES-1:0]  rldLd;
    logic [BYTE_W-1:0] wdata;
  } evt_strobe_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evt_strobe_t       strb,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  rldVal,
  output logic              cntZero
);
  logic [CNT_W-1:0] cntReg, rldReg, cntNext, rldNext;

  assign cntZero = (cntReg == '0);

  always_comb begin
    cntNext = cntReg;
    if (strb.dec) cntNext = cntZero ? rldReg : cntReg - 1'b1;
    rldNext = rldReg;
    for (int l = 0; l < LANES; l++) begin
      if (strb.cntLd[l]) cntNext[l*BYTE_W +: BYTE_W] = strb.wdata;
      if (strb.rldLd[l]) rldNext[l*BYTE_W +: BYTE_W] = strb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
      rldReg <= '0;
    end else begin
      cntReg <= cntNext;
      rldReg <= rldNext;
    end
  end

  assign cntVal = cntReg;
  assign rldVal = rldReg;
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntPin,
  input  logic              evtPin,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  rldVal,
  input  logic              cntZero,
  output evt_strobe_t       strb,
  output logic              pendA,
  output logic              pendB,
  output logic              enA,
  output logic              enB,
  output logic              irq
);
  logic syncA, syncB, prevA, prevB;
  logic riseA, fallA, riseB, edgeA;
  logic edgeSel;
  logic ctrlWr, statWr, clrA, clrB, underflow;
  logic [LANES-1:0] cntLd, rldLd;

  evt_sync #(.STAGES(SYNC_N)) uSyncA (.clk(clk), .rstN(rstN), .din(cntPin), .dout(syncA));
  evt_sync #(.STAGES(SYNC_N)) uSyncB (.clk(clk), .rstN(rstN), .din(evtPin), .dout(syncB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= syncA;
      prevB <= syncB;
    end
  end

  assign riseA = syncA & ~prevA;
  assign fallA = ~syncA & prevA;
  assign riseB = syncB & ~prevB;
  assign edgeA = edgeSel ? fallA : riseA;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cntLd[l] = busWe && (busAddr == ADDR_W'(l));
      assign rldLd[l] = busWe && (busAddr == ADDR_W'(LANES + l));
    end
  endgenerate

  assign ctrlWr = busWe && (busAddr == ADDR_W'(CTRL_ADDR));
  assign statWr = busWe && (busAddr == ADDR_W'(STAT_ADDR));
  assign clrA   = statWr & busWdata[0];
  assign clrB   = statWr & busWdata[1];

  assign strb.dec   = edgeA & ~(|cntLd);
  assign strb.cntLd = cntLd;
  assign strb.rldLd = rldLd;
  assign strb.wdata = busWdata;
  assign underflow  = strb.dec & cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSel <= 1'b0;
      enA     <= 1'b0;
      enB     <= 1'b0;
      pendA   <= 1'b0;
      pendB   <= 1'b0;
    end else begin
      if (ctrlWr) {enB, enA, edgeSel} <= busWdata[2:0];
      pendA <= underflow | (pendA & ~clrA);
      pendB <= riseB     | (pendB & ~clrB);
    end
  end

  assign irq = (pendA & enA) | (pendB & enB);

  always_comb begin
    busRdata = '0;
    for (int l = 0; l < LANES; l++) begin
      if (busAddr == ADDR_W'(l))         busRdata = cntVal[l*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_W'(LANES + l)) busRdata = rldVal[l*BYTE_W +: BYTE_W];
    end
    if (busAddr == ADDR_W'(CTRL_ADDR)) busRdata[2:0] = {enB, enA, edgeSel};
    if (busAddr == ADDR_W'(STAT_ADDR)) busRdata[1:0] = {pendB, pendA};
  end
endmodule

// File: rtl/evt_counter_timer.sv
module evt_counter_timer
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntPin,
  input  logic              evtPin,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              irq
);
  evt_strobe_t      strb;
  logic [CNT_W-1:0] cntVal, rldVal;
  logic             cntZero, pendA, pendB, enA, enB;

  evt_timer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .evtPin(evtPin),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .rldVal(rldVal), .cntZero(cntZero), .strb(strb),
    .pendA(pendA), .pendB(pendB), .enA(enA), .enB(enB), .irq(irq)
  );

  evt_timer_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntVal(cntVal), .rldVal(rldVal), .cntZero(cntZero)
  );
endmodule

// File: rtl/evt_counter_timer_chk.sv
module evt_counter_timer_chk
  import evt_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dec,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  rldVal,
  input logic              pendA,
  input logic              pendB,
  input logic              enA,
  input logic              enB,
  input logic              irq
);
  logic cntWr, statWr;
  assign cntWr  = busWe && (busAddr < ADDR_W'(LANES));
  assign statWr = busWe && (busAddr == ADDR_W'(STAT_ADDR));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dec && !cntWr |=> $stable(cntVal));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    dec && cntVal != '0 |=> cntVal == $past(cntVal) - 1'b1);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    dec && cntVal == '0 |=> cntVal == $past(rldVal) && pendA);

  a_r7_sticky_a: assert property (@(posedge clk) disable iff (!rstN)
    pendA && !(statWr && busWdata[0]) |=> pendA);

  a_r7_sticky_b: assert property (@(posedge clk) disable iff (!rstN)
    pendB && !(statWr && busWdata[1]) |=> pendB);

  a_r8_masked: assert property (@(posedge clk) disable iff (!rstN)
    !enA && !enB |-> !irq);

  a_r8_raise: assert property (@(posedge clk) disable iff (!rstN)
    (pendA && enA) || (pendB && enB) |-> irq);
endmodule

bind evt_counter_timer evt_counter_timer_chk uChk (
  .clk(clk), .rstN(rstN), .dec(strb.dec), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .cntVal(cntVal), .rldVal(rldVal), .pendA(pendA),
  .pendB(pendB), .enA(enA), .enB(enB), .irq(irq)
);

// File: tb/evt_counter_timer_tb.sv
`timescale 1ns/1ps
module evt_counter_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntPin = 1'b0, evtPin = 1'b0, busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq;
  int         checks = 0, failures = 0;

  always #2 clk = ~clk;

  evt_counter_timer u_dut (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .evtPin(evtPin), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    busWe = 1'b1; busAddr = 3'(addr); busWdata = 8'(data);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(int addr, output int data);
    busAddr = 3'(addr);
    #0.5;
    data = int'(busRdata);
  endtask

  task automatic rdCnt(output int v);
    int lo, hi;
    rd(0, lo); rd(1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic setCnt(int v);
    wr(0, v & 255); wr(1, v >> 8);
  endtask

  task automatic setRld(int v);
    wr(2, v & 255); wr(3, v >> 8);
  endtask

  task automatic pulseA();
    @(negedge clk); cntPin = 1'b1;
    repeat (4) @(negedge clk);
    cntPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, c, fa, st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R9 byte write/read of counter and reload
    setCnt(16'h1234); setRld(16'hA5C3);
    rdCnt(v); chk("R9 counter bytes", v, 16'h1234);
    rd(2, v); chk("R9 reload low", v, 16'hC3);
    rd(3, v); chk("R9 reload high", v, 16'hA5);

    // R3 R5 sweep: several reload values, arithmetic model
    for (int rl = 0; rl < 4; rl++) begin
      setRld(rl); setCnt(2); wr(5, 3);
      c = 2; fa = 0;
      for (int p = 0; p < 9; p++) begin
        pulseA();
        if (c == 0) begin c = rl; fa = 1; end else c = c - 1;
        rdCnt(v); chk("R3/R5 count after rising pulse", v, c);
        rd(5, st); chk("R5 pending A", st & 1, fa);
      end
    end

    // R3 latency: change visible only after third edge
    setRld(100); setCnt(50);
    @(negedge clk); cntPin = 1'b1;
    @(negedge clk);
    @(negedge clk); rdCnt(v); chk("R3 no step before third edge", v, 50);
    @(negedge clk); rdCnt(v); chk("R3 step after third edge", v, 49);
    // R4 rising mode: falling transition ignored
    cntPin = 1'b0; repeat (5) @(negedge clk);
    rdCnt(v); chk("R4 falling ignored in rising mode", v, 49);

    // R4 falling mode
    wr(4, 1);
    @(negedge clk); cntPin = 1'b1; repeat (5) @(negedge clk);
    rdCnt(v); chk("R4 rising ignored in falling mode", v, 49);
    // R4 select change while pin steady high
    wr(4, 0); repeat (4) @(negedge clk);
    wr(4, 1); repeat (4) @(negedge clk);
    rdCnt(v); chk("R4 select change no step", v, 49);
    cntPin = 1'b0; repeat (5) @(negedge clk);
    rdCnt(v); chk("R4 falling counted", v, 48);
    wr(4, 0);

    // R8 irq masking with pending A
    setCnt(0); wr(5, 3); pulseA();
    rd(5, st); chk("R5 pending A from zero", st & 1, 1);
    chk("R8 irq masked", int'(irq), 0);
    wr(4, 2); chk("R8 irq with enable A", int'(irq), 1);
    wr(5, 2); rd(5, st); chk("R7 write zero bit keeps A", st & 1, 1);
    wr(5, 1); rd(5, st); chk("R7 clear A", st & 1, 0);
    chk("R8 irq after clear", int'(irq), 0);

    // R6 pin B
    setCnt(77);
    @(negedge clk); evtPin = 1'b1; repeat (5) @(negedge clk);
    rd(5, st); chk("R6 pending B on rise", (st >> 1) & 1, 1);
    chk("R8 irq B masked", int'(irq), 0);
    wr(4, 4); chk("R8 irq with enable B", int'(irq), 1);
    wr(5, 2); rd(5, st); chk("R7 clear B", (st >> 1) & 1, 0);
    evtPin = 1'b0; repeat (5) @(negedge clk);
    rd(5, st); chk("R6 falling B ignored", (st >> 1) & 1, 0);
    rdCnt(v); chk("R6 counter untouched", v, 77);

    // R7 set wins over clear in the same cycle
    @(negedge clk); evtPin = 1'b1;
    @(negedge clk);
    @(negedge clk); busWe = 1'b1; busAddr = 3'd5; busWdata = 8'd2;
    @(negedge clk); busWe = 1'b0;
    rd(5, st); chk("R7 set wins", (st >> 1) & 1, 1);
    chk("R8 irq set wins", int'(irq), 1);
    wr(5, 2); evtPin = 1'b0;

    // R9 write discards colliding edge
    wr(4, 0); setCnt(10); repeat (2) @(negedge clk);
    @(negedge clk); cntPin = 1'b1;
    @(negedge clk);
    @(negedge clk); busWe = 1'b1; busAddr = 3'd0; busWdata = 8'd7;
    @(negedge clk); busWe = 1'b0;
    rdCnt(v); chk("R9 write wins over edge", v, 7);
    cntPin = 1'b0; repeat (5) @(negedge clk);
    rdCnt(v); chk("R2 counter holds", v, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule